// File: doc/BRIEF.md
# Difference-Table Integer Cube Root Engine

This block computes the ceiling integer cube root of an unsigned input word. It returns the smallest integer `r` whose cube is at least `x`. It never multiplies. It steps a counter upward one value at a time and keeps the cube of that counter current with three accumulators of forward differences. The first difference is the gap between successive cubes. The second difference is six times the counter. The third difference is the constant six. Each step is therefore a handful of additions, and one magnitude compare decides when the search stops.

A one-cycle start pulse (for example, from a debounced push button) captures the input word and begins a run. The controller is a small algorithmic state machine with five states: idle, initialise, test, step and finished. It drives the datapath through a packed struct of strobes. When the run ends, the done flag rises. The result then holds steady until the next start pulse.

Top module: `cube_root_engine`

## Requirements
- R1: When done is high, root equals the smallest integer r with r*r*r >= x, where x is the value of xIn captured at the accepted start. This holds for every 12-bit x, so x = 4095 gives 16 and x = 125 gives 5.
- R2: The internal running cube always equals the search counter cubed. It is built from additions only.
- R3: The first-difference accumulator always equals 3r²+3r+1 and the second-difference accumulator always equals 6r, where r is the current counter value.
- R4: When start is high in the idle or finished state, xIn is captured and done reads 0 after the next clock edge.
- R5: done rises exactly 2r+2 rising edges after the edge that accepted start, where r is the resulting root.
- R6: An input of 0 finishes after 2 edges with root 0.
- R7: A start pulse while a computation is in progress has no effect on the result or the latency.
- R8: In the finished state with start low, done stays 1 and root stays constant, whatever xIn does.
- R9: While rstN is low, and after it is released, done is 0 and root is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| xIn | input | 12 | Unsigned operand |
| root | output | 5 | Ceiling cube root, valid while done is 1 |
| done | output | 1 | High while the result is held |

## Verification
A wrong accumulator shows up in two places at the ports: in the root value, and in the run length. The loop stops on the first cube at or above x, so one bad difference moves the stop point at the first step after the error. Sweeping all 4096 operands and checking the cycle count of every run catches both an off-by-one in the compare and a stalled or skipped update. A controller that reacts to start at the wrong time changes either the latency or the held result of the run that is already under way.

// File: rtl/cbrt_pkg.sv
package cbrt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_TEST, ST_STEP, ST_DONE
  } cbrtState_t;

  typedef struct packed {
    logic capture;
    logic clear;
    logic advance;
  } dpCtrl_t;
endpackage

// File: rtl/cbrt_ctrl.sv
module cbrt_ctrl
  import cbrt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    reached,
  output dpCtrl_t dpCtrl,
  output logic    done
);
  cbrtState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    dpCtrl   = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          nxtState       = ST_INIT;
          dpCtrl.capture = 1'b1;
        end
      end
      ST_INIT: begin
        dpCtrl.clear = 1'b1;
        nxtState     = ST_TEST;
      end
      ST_TEST: nxtState = reached ? ST_DONE : ST_STEP;
      ST_STEP: begin
        dpCtrl.advance = 1'b1;
        nxtState       = ST_TEST;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

  logic busy;
  assign busy = (state == ST_INIT) || (state == ST_TEST) || (state == ST_STEP);

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (((state == ST_IDLE) || (state == ST_DONE)) && start) |=> (state == ST_INIT)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (state != ST_INIT)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R8
endmodule

// File: rtl/cbrt_datapath.sv
module cbrt_datapath
  import cbrt_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int ROOT_W = 5,
  parameter int CUBE_W = IN_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [IN_W-1:0]   xIn,
  output logic [ROOT_W-1:0] root,
  output logic              reached
);
  localparam logic [CUBE_W-1:0] THIRD_DIFF = CUBE_W'(6);

  logic [IN_W-1:0]   xReg;
  logic [ROOT_W-1:0] cnt;
  logic [CUBE_W-1:0] cube, diff1, diff2, diff2Next;

  assign diff2Next = diff2 + THIRD_DIFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg  <= '0;
      cnt   <= '0;
      cube  <= '0;
      diff1 <= CUBE_W'(1);
      diff2 <= '0;
    end else begin
      if (dpCtrl.capture) xReg <= xIn;
      if (dpCtrl.clear) begin
        cnt   <= '0;
        cube  <= '0;
        diff1 <= CUBE_W'(1);
        diff2 <= '0;
      end else if (dpCtrl.advance) begin
        cnt   <= cnt + ROOT_W'(1);
        cube  <= cube + diff1;
        diff2 <= diff2Next;
        diff1 <= diff1 + diff2Next;
      end
    end
  end

  assign reached = (cube >= CUBE_W'(xReg));
  assign root    = cnt;

  AST_CUBE_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    int'(cube) == int'(cnt) * int'(cnt) * int'(cnt)); // R2
  AST_FIRST_DIFF: assert property (@(posedge clk) disable iff (!rstN)
    int'(diff1) == 3 * int'(cnt) * int'(cnt) + 3 * int'(cnt) + 1); // R3
  AST_SECOND_DIFF: assert property (@(posedge clk) disable iff (!rstN)
    int'(diff2) == 6 * int'(cnt)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.advance |-> !reached); // R1
endmodule

// File: rtl/cube_root_engine.sv
module cube_root_engine
  import cbrt_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int ROOT_W = (IN_W + 2) / 3 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IN_W-1:0]   xIn,
  output logic [ROOT_W-1:0] root,
  output logic              done
);
  localparam int CUBE_W = IN_W + 3;

  dpCtrl_t dpCtrl;
  logic    reached;

  cbrt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reached(reached),
    .dpCtrl(dpCtrl), .done(done)
  );

  cbrt_datapath #(.IN_W(IN_W), .ROOT_W(ROOT_W), .CUBE_W(CUBE_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .xIn(xIn),
    .root(root), .reached(reached)
  );

  AST_DONE_REACHED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reached); // R1
  AST_ROOT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(root)); // R8
endmodule

// File: tb/test_cube_root_engine.sv
module test_cube_root_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] xIn = '0;
  logic [4:0]  root;
  logic        done;
  int          checks = 0;
  int          bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  cube_root_engine i_cube_root_engine (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .root(root), .done(done)
  );

  localparam int NVEC = 8;
  localparam int VEC_X [NVEC] = '{125, 0, 1, 2, 8, 9, 4095, 4096 - 1 - 1000};
  localparam int VEC_R [NVEC] = '{5, 0, 1, 2, 2, 3, 16, 15};

  function automatic int refRoot(int x);
    int r = 0;
    while (r * r * r < x) r++;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart(int x);
    @(negedge clk);
    xIn = 12'(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int edges);
    edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic runOne(int x, int expRoot, bit full);
    int edges;
    pulseStart(x);
    if (full) check("R4 done low after start", int'(done), 0);
    waitDone(edges);
    check("R1/R2/R3 root", int'(root), expRoot);
    check("R5 latency", edges, 2 * expRoot + 2);
  endtask

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    check("R9 done in reset", int'(done), 0);
    check("R9 root in reset", int'(root), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 done after reset", int'(done), 0);
    check("R9 root after reset", int'(root), 0);

    for (int i = 0; i < NVEC; i++) runOne(VEC_X[i], VEC_R[i], 1'b1);

    // R6 zero input
    pulseStart(0);
    waitDone(edges);
    check("R6 zero root", int'(root), 0);
    check("R6 zero latency", edges, 2);

    // R8 hold while xIn changes
    pulseStart(27);
    waitDone(edges);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      xIn = 12'(k * 500 + 3);
    end
    check("R8 done held", int'(done), 1);
    check("R8 root held", int'(root), 3);

    // R7 start while busy is ignored
    pulseStart(4095);
    repeat (4) @(negedge clk);
    xIn = 12'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(edges);
    check("R7 root unaffected", int'(root), 16);
    check("R7 latency unaffected", edges + 5, 34);

    // R1 full sweep
    for (int x = 0; x < 4096; x++) runOne(x, refRoot(x), 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule